// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core takes next. It watches five request lines. In order of precedence they are a non-maskable trap line, three restart lines at fixed vectors (called high, middle and low here) and a general request line. The general line gets no vector: its device supplies the instruction to execute. The controller holds a mask bit for each restart line and one global enable. It samples the request lines only when the core marks an instruction boundary. It then issues a one-cycle take pulse together with a source code and, for the restart and trap sources, a 16-bit branch address.

The highest restart line is captured on a rising edge and stays pending until it is serviced or cleared by command. The middle and low restart lines and the general line act on their level. The trap line counts a rising edge only while the line stays high, so one assertion yields one acceptance. Any vectored acceptance raises a request for the core to save the program counter on the stack. No further interrupt is arbitrated until the core answers that request. An accepted general request instead produces a one-cycle acknowledge, during which the core reads the instruction from the external bus.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, take, intr_ack and push_req are 0, all three restart masks are set, the global enable is clear, and status_word reads 0x07.
- R2: When several sources are eligible at the same boundary, the one taken is the first in this order: trap, restart-high, restart-middle, restart-low, general.
- R3: take_src codes are 5 trap, 4 restart-high, 3 restart-middle, 2 restart-low, 1 general. take_vector is 0x0024, 0x003C, 0x0034, 0x002C for codes 5, 4, 3, 2 and 0x0000 for code 1.
- R4: The trap source is accepted regardless of the masks and of the global enable.
- R5: A restart source is eligible only with the global enable set and its mask bit clear. The general line needs only the global enable. A cmd_wr with cmd_data[3]=1 loads the masks from cmd_data[0] (low), cmd_data[1] (middle) and cmd_data[2] (high), where 1 means masked. With cmd_data[3]=0 the masks are left unchanged.
- R6: Every acceptance clears the global enable. Only ei_cmd sets it again, and di_cmd clears it.
- R7: A rising edge on the restart-high line sets a pending latch that holds after the line settles. The latch is cleared by accepting that source or by cmd_wr with cmd_data[4]=1.
- R8: A trap edge is accepted only if the line is still high at the boundary. A line that stays high is accepted once.
- R9: Arbitration happens only on a cycle with insn_boundary high. take is high for exactly the cycle after that edge.
- R10: A vectored acceptance raises push_req, which stays high until push_done. While push_req is high, nothing is accepted.
- R11: Accepting the general line pulses intr_ack together with take, and leaves push_req low.
- R12: status_word bits are [0] low mask, [1] middle mask, [2] high mask, [3] global enable, [4] low line level, [5] middle line level, [6] restart-high pending latch, [7] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Non-maskable trap line |
| rsth_req | input | 1 | Restart-high line (edge captured) |
| rstm_req | input | 1 | Restart-middle line (level) |
| rstl_req | input | 1 | Restart-low line (level) |
| intr_req | input | 1 | General request line (level) |
| insn_boundary | input | 1 | Instruction-boundary strobe from the core |
| cmd_wr | input | 1 | Mask/clear command strobe |
| cmd_data | input | 5 | Command fields (see R5, R7) |
| ei_cmd | input | 1 | Set global enable |
| di_cmd | input | 1 | Clear global enable |
| push_done | input | 1 | Core has saved the program counter |
| take | output | 1 | One-cycle interrupt take pulse |
| take_src | output | 3 | Code of the source taken |
| take_vector | output | 16 | Branch address of the source taken |
| intr_ack | output | 1 | Acknowledge for the general line |
| push_req | output | 1 | Request to save the program counter |
| status_word | output | 8 | Masks, enable and pending lines |

## Verification
The hardest case to reach from the ports is a second trap edge that arrives while an earlier vectored acceptance is still waiting for push_done. The bench gets there by holding back push_done after a trap is taken. It then drops and re-raises the trap line and strobes a boundary, so the new edge is pending but blocked. After push_done it shows the same edge being taken, and it shows that a line left high is not taken again. The restart-high latch also needs care. It is set while the global enable is clear, so it stays pending, and it is then cleared by command before enable returns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 5;
  localparam int CODE_W = 3;
  localparam int VEC_W  = 16;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_GEN  = 3'd1,
    SRC_RSTL = 3'd2,
    SRC_RSTM = 3'd3,
    SRC_RSTH = 3'd4,
    SRC_TRAP = 3'd5
  } irq_src_e;

  // branch address for a source code; the general source has none
  function automatic logic [VEC_W-1:0] src_vector(input irq_src_e s);
    case (s)
      SRC_TRAP: src_vector = VEC_W'(16'h0024);
      SRC_RSTH: src_vector = VEC_W'(16'h003C);
      SRC_RSTM: src_vector = VEC_W'(16'h0034);
      SRC_RSTL: src_vector = VEC_W'(16'h002C);
      default:  src_vector = '0;
    endcase
  endfunction

  // true when the source needs the program counter saved
  function automatic logic src_is_vectored(input irq_src_e s);
    src_is_vectored = (s != SRC_NONE) && (s != SRC_GEN);
  endfunction
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_req,
  input  logic rsth_req,
  input  logic take_trap,
  input  logic take_rsth,
  input  logic clr_rsth,
  output logic trap_pend,
  output logic rsth_pend
);
  logic trap_q, rsth_q;
  logic trap_rise, rsth_rise;

  assign trap_rise = trap_req & ~trap_q;
  assign rsth_rise = rsth_req & ~rsth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q    <= 1'b0;
      rsth_q    <= 1'b0;
      trap_pend <= 1'b0;
      rsth_pend <= 1'b0;
    end else begin
      trap_q <= trap_req;
      rsth_q <= rsth_req;
      // trap edge is kept only while the line stays high
      trap_pend <= (trap_pend | trap_rise) & trap_req & ~take_trap;
      // a new edge wins over a clear in the same cycle
      if (rsth_rise)
        rsth_pend <= 1'b1;
      else if (take_rsth || clr_rsth)
        rsth_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             accept,
  output logic [2:0]       mask,
  output logic             gie,
  output logic             clr_rsth
);
  localparam int MSK_APPLY = 3;
  localparam int CLR_BIT   = 4;

  assign clr_rsth = cmd_wr & cmd_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= 3'b111;
      gie  <= 1'b0;
    end else begin
      if (cmd_wr && cmd_data[MSK_APPLY])
        mask <= cmd_data[2:0];
      // acceptance overrides an enable in the same cycle
      if (accept || di_cmd)
        gie <= 1'b0;
      else if (ei_cmd)
        gie <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick
  import irq_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic [NS-1:0] elig,
  output irq_src_e      pick
);
  // index i maps to code i+1; higher index wins
  always_comb begin
    pick = SRC_NONE;
    for (int i = 0; i < NS; i++) begin
      if (elig[i]) pick = irq_src_e'(CODE_W'(i + 1));
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int CMD_W    = 5,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_req,
  input  logic                rsth_req,
  input  logic                rstm_req,
  input  logic                rstl_req,
  input  logic                intr_req,
  input  logic                insn_boundary,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_data,
  input  logic                ei_cmd,
  input  logic                di_cmd,
  input  logic                push_done,
  output logic                take,
  output logic [CODE_W-1:0]   take_src,
  output logic [VEC_W-1:0]    take_vector,
  output logic                intr_ack,
  output logic                push_req,
  output logic [STATUS_W-1:0] status_word
);
  logic [2:0]       mask;
  logic             gie, clr_rsth;
  logic             trap_pend, rsth_pend;
  logic [N_SRC-1:0] elig;
  irq_src_e         pick;
  logic             accept;
  logic             take_q, ack_q, push_q;
  irq_src_e         src_q;
  logic [VEC_W-1:0] vec_q;

  irq_enable_regs #(.CMD_W(CMD_W)) u_en (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .accept(accept),
    .mask(mask), .gie(gie), .clr_rsth(clr_rsth)
  );

  irq_edge_capture u_cap (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .rsth_req(rsth_req),
    .take_trap(accept && pick == SRC_TRAP),
    .take_rsth(accept && pick == SRC_RSTH),
    .clr_rsth(clr_rsth),
    .trap_pend(trap_pend), .rsth_pend(rsth_pend)
  );

  assign elig[0] = intr_req & gie;
  assign elig[1] = rstl_req & gie & ~mask[0];
  assign elig[2] = rstm_req & gie & ~mask[1];
  assign elig[3] = rsth_pend & gie & ~mask[2];
  assign elig[4] = trap_pend & trap_req;

  irq_priority_pick #(.NS(N_SRC)) u_pick (.elig(elig), .pick(pick));

  assign accept = insn_boundary & ~push_q & (pick != SRC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      push_q <= 1'b0;
      src_q  <= SRC_NONE;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      ack_q  <= accept && (pick == SRC_GEN);
      if (accept) begin
        src_q <= pick;
        vec_q <= src_vector(pick);
      end
      if (accept && src_is_vectored(pick))
        push_q <= 1'b1;
      else if (push_done)
        push_q <= 1'b0;
    end
  end

  assign take        = take_q;
  assign take_src    = src_q;
  assign take_vector = vec_q;
  assign intr_ack    = ack_q;
  assign push_req    = push_q;
  assign status_word = STATUS_W'({1'b0, rsth_pend, rstm_req, rstl_req, gie, mask});
endmodule

module irq_vector_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_boundary,
  input logic              accept,
  input logic              take,
  input logic [CODE_W-1:0] take_src,
  input logic [VEC_W-1:0]  take_vector,
  input logic              intr_ack,
  input logic              push_req,
  input logic [7:0]        status_word
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_boundary)); // R9
  AST_ACCEPT_GIVES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> take); // R9
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !status_word[3]); // R6
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_src == SRC_TRAP) |-> take_vector == 16'h0024); // R3
  AST_ACK_ONLY_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> (take && take_src == SRC_GEN && !push_req)); // R11
  AST_PUSH_ON_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_src != SRC_GEN) |-> push_req); // R10
  AST_NO_TAKE_WHILE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(push_req)); // R10
  AST_MID_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_src == SRC_RSTM) |-> ($past(status_word[3]) && !$past(status_word[1]))); // R5
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .accept(accept),
  .take(take), .take_src(take_src), .take_vector(take_vector),
  .intr_ack(intr_ack), .push_req(push_req), .status_word(status_word)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 0, rsth_req = 0, rstm_req = 0, rstl_req = 0, intr_req = 0;
  logic insn_boundary = 0, cmd_wr = 0, ei_cmd = 0, di_cmd = 0, push_done = 0;
  logic [4:0]  cmd_data = '0;
  logic        take, intr_ack, push_req;
  logic [2:0]  take_src;
  logic [15:0] take_vector;
  logic [7:0]  status_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic        c_take, c_ack, c_push;
  logic [2:0]  c_src;
  logic [15:0] c_vec;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .rsth_req(rsth_req),
    .rstm_req(rstm_req), .rstl_req(rstl_req), .intr_req(intr_req),
    .insn_boundary(insn_boundary), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .push_done(push_done),
    .take(take), .take_src(take_src), .take_vector(take_vector),
    .intr_ack(intr_ack), .push_req(push_req), .status_word(status_word)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic boundary();
    @(negedge clk);
    insn_boundary = 1;
    @(posedge clk);
    #1;
    c_take = take; c_src = take_src; c_vec = take_vector;
    c_ack = intr_ack; c_push = push_req;
    @(negedge clk);
    insn_boundary = 0;
  endtask

  task automatic push_ack();
    @(negedge clk); push_done = 1;
    @(negedge clk); push_done = 0;
  endtask

  task automatic enable();
    @(negedge clk); ei_cmd = 1;
    @(negedge clk); ei_cmd = 0;
  endtask

  task automatic command(input logic [4:0] d);
    @(negedge clk); cmd_wr = 1; cmd_data = d;
    @(negedge clk); cmd_wr = 0; cmd_data = '0;
  endtask

  task automatic t_reset();
    check("R1", "take", take, 0);
    check("R1", "push_req", push_req, 0);
    check("R1", "intr_ack", intr_ack, 0);
    check("R1/R12", "status", status_word, 8'h07);
    intr_req = 1;
    boundary();
    check("R5", "general with enable clear", c_take, 0);
    check("R5", "ack with enable clear", c_ack, 0);
    intr_req = 0;
  endtask

  task automatic t_trap();
    trap_req = 1;
    tick();
    boundary();
    check("R4", "trap taken with masks set", c_take, 1);
    check("R3", "trap code", c_src, 5);
    check("R3", "trap vector", c_vec, 16'h0024);
    check("R10", "push_req after trap", c_push, 1);
    tick();
    check("R9", "take one cycle", take, 0);
    trap_req = 0; tick(); trap_req = 1; tick();
    boundary();
    check("R10", "blocked during push", c_take, 0);
    push_ack();
    check("R10", "push_req released", push_req, 0);
    boundary();
    check("R10", "pending trap after push", c_take, 1);
    check("R3", "trap code again", c_src, 5);
    push_ack();
    boundary();
    check("R8", "held trap not retaken", c_take, 0);
    trap_req = 0;
    tick();
    trap_req = 1; tick(); trap_req = 0; tick();
    boundary();
    check("R8", "dropped trap ignored", c_take, 0);
  endtask

  task automatic t_enable();
    command(5'h08);
    enable();
    check("R12", "status unmasked enabled", status_word, 8'h08);
    rstl_req = 1;
    boundary();
    check("R5", "low taken", c_take, 1);
    check("R3", "low code", c_src, 2);
    check("R3", "low vector", c_vec, 16'h002C);
    check("R6", "enable cleared", status_word[3], 0);
    push_ack();
    boundary();
    check("R6", "no retake without ei", c_take, 0);
    enable();
    boundary();
    check("R6", "retake after ei", c_take, 1);
    push_ack();
    enable();
    @(negedge clk); di_cmd = 1; @(negedge clk); di_cmd = 0;
    boundary();
    check("R6", "di blocks", c_take, 0);
    rstl_req = 0;
  endtask

  task automatic t_priority();
    enable();
    rstl_req = 1; rstm_req = 1; intr_req = 1; rsth_req = 1;
    tick();
    check("R7/R12", "status all pending", status_word, 8'h78);
    boundary();
    check("R2", "high first", c_src, 4);
    check("R3", "high vector", c_vec, 16'h003C);
    check("R7", "latch cleared by accept", status_word, 8'h30);
    push_ack(); enable();
    boundary();
    check("R2", "middle next", c_src, 3);
    check("R3", "middle vector", c_vec, 16'h0034);
    push_ack(); enable(); rstm_req = 0;
    boundary();
    check("R2", "low next", c_src, 2);
    push_ack(); enable(); rstl_req = 0;
    boundary();
    check("R11", "general code", c_src, 1);
    check("R11", "ack", c_ack, 1);
    check("R3", "general vector", c_vec, 0);
    check("R11", "no push", c_push, 0);
    tick();
    check("R11", "ack one cycle", intr_ack, 0);
    intr_req = 0; rsth_req = 0;
  endtask

  task automatic t_mask();
    enable();
    command(5'h0A);
    rstm_req = 1;
    boundary();
    check("R5", "masked middle ignored", c_take, 0);
    command(5'h00);
    check("R5", "mask kept without apply", status_word[2:0], 3'b010);
    rstl_req = 1;
    boundary();
    check("R2", "low over masked middle", c_src, 2);
    push_ack();
    rstm_req = 0; rstl_req = 0;
  endtask

  task automatic t_latch();
    rsth_req = 1; tick(); rsth_req = 0; tick();
    check("R7", "latch holds", status_word, 8'h42);
    command(5'h10);
    check("R7", "latch cleared by command", status_word, 8'h02);
    enable();
    boundary();
    check("R7", "cleared latch not taken", c_take, 0);
    rsth_req = 1; trap_req = 1; tick();
    boundary();
    check("R2", "trap over high", c_src, 5);
    push_ack();
    trap_req = 0; rsth_req = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_trap();
    t_enable();
    t_priority();
    t_mask();
    t_latch();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule